// File: doc/BRIEF.md
# Multi-CPU Level Interrupt Aggregator

This block collects a wide set of level-sensitive interrupt lines and reduces them to one interrupt request per processor. Sources are grouped into 32-bit words, and the number of words is a parameter. Each processor owns a separate bank of mask state. All banks see the same raw source lines, but each bank decides for itself which sources may reach its own processor. Software selects a bank with a CPU select input. It then sets or clears mask bits with write-one registers, so no read-modify-write sequence is needed. It can also read back the raw source levels and the mask of that bank.

The register space of one bank is laid out by register group. All raw-status words come first, then all mask-status words, then all mask-set words, then all mask-clear words. Offsets therefore scale with the configured word count. The register port is a plain request interface. It has no wait states, and read data appears one cycle after the request. The CPU outputs are registered levels. Each output follows its sources and its mask one clock behind.

Top module: `lvl_irq_agg`

## Requirements
- R1: After reset every mask bit of every bank is 1, every `irq_out` bit is 0 and `rdata` is 0.
- R2: Register byte offset is (group*N_WORDS + word)*4, where group 0 is raw status, 1 is mask status, 2 is mask set and 3 is mask clear. Address bits [1:0] are ignored. Source n maps to word n/32, bit n%32.
- R3: A read of a raw-status word returns the current source levels of that word, whether or not they are masked.
- R4: A write to a mask-set word sets each mask bit whose `wdata` bit is 1, in the selected bank only. Bits written 0 keep their value.
- R5: A write to a mask-clear word clears each mask bit whose `wdata` bit is 1, in the selected bank only. Bits written 0 keep their value.
- R6: A read of a mask-status, mask-set or mask-clear word returns the current mask word of the selected bank (1 = masked).
- R7: Writes to raw-status or mask-status words change no mask bit and no output.
- R8: Mask changes in one bank never affect another bank's mask or that bank's `irq_out` bit.
- R9: `irq_out[c]` is 1 exactly when some source was high and unmasked in bank c. It is updated one clock after a source change or a mask write.
- R10: An access at byte offset 16*N_WORDS or above reads as zero, and a write there changes nothing.
- R11: A read request (`req`=1, `we`=0) loads `rdata` at the next clock edge. `rdata` holds its value in cycles without a read request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src | input | 32*N_WORDS | Level interrupt sources, already synchronous |
| req | input | 1 | Register access request for this cycle |
| we | input | 1 | 1 = write, 0 = read |
| cpu_sel | input | max(1,clog2(N_CPUS)) | Bank (CPU) addressed by the access |
| addr | input | ADDR_W | Byte address inside the bank |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, one cycle after the request |
| irq_out | output | N_CPUS | Per-CPU interrupt request, level |

## Verification
The assertions check several properties on every clock cycle. A set write must leave its written ones masked, and a clear write must leave its written ones unmasked. A write to a read-only or unmapped word must leave all masks stable. An unmapped read must return zero, and a raw-status read must return the sampled sources. An asserted output must be backed by a source that was high in the previous cycle.

Other properties can only be shown by the bench scenarios. One is that a mask change in one bank leaves the other bank alone. Others are that zero bits in set and clear writes have no effect, and that all three mask-facing groups read back the same word. The bench also checks the word and bit position of a high-numbered source, and that `rdata` holds between reads.

// File: rtl/lia_pkg.sv
package lia_pkg;
  localparam int WORD_BITS = 32;
  localparam int GROUPS    = 4;

  typedef enum logic [1:0] {
    GRP_RAW   = 2'd0,
    GRP_MSTAT = 2'd1,
    GRP_MSET  = 2'd2,
    GRP_MCLR  = 2'd3
  } grp_e;
endpackage

// File: rtl/lia_decode.sv
module lia_decode #(
  parameter int N_WORDS = 2,
  parameter int ADDR_W  = 8,
  localparam int WIDX_W = (N_WORDS > 1) ? $clog2(N_WORDS) : 1
) (
  input  logic [ADDR_W-1:0] addr,
  output lia_pkg::grp_e     grp,
  output logic [WIDX_W-1:0] word,
  output logic              hit
);
  import lia_pkg::*;

  localparam int SLOTS = GROUPS * N_WORDS;

  int unsigned slot, gi, wi;
  logic [1:0]  unused_lo;

  // Registers are packed by group: slot = group*N_WORDS + word.
  assign unused_lo = addr[1:0];

  always_comb begin
    slot = 32'(addr[ADDR_W-1:2]);
    hit  = (slot < SLOTS);
    gi   = slot / N_WORDS;
    wi   = slot % N_WORDS;
    grp  = grp_e'(gi[1:0]);
    word = wi[WIDX_W-1:0];
  end
endmodule

// File: rtl/lia_mask_bank.sv
module lia_mask_bank #(
  parameter int N_WORDS = 2,
  localparam int N_SRC  = N_WORDS * lia_pkg::WORD_BITS,
  localparam int WIDX_W = (N_WORDS > 1) ? $clog2(N_WORDS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  lia_pkg::grp_e     grp,
  input  logic [WIDX_W-1:0] word,
  input  logic [31:0]       wdata,
  input  logic [N_SRC-1:0]  src,
  output logic [N_SRC-1:0]  mask,
  output logic              irq
);
  import lia_pkg::*;

  logic [N_SRC-1:0] mask_q, mask_d;
  logic             irq_q;

  always_comb begin
    mask_d = mask_q;
    if (wr_en) begin
      unique case (grp)
        GRP_MSET: mask_d[WORD_BITS*word +: WORD_BITS] = mask_q[WORD_BITS*word +: WORD_BITS] | wdata;
        GRP_MCLR: mask_d[WORD_BITS*word +: WORD_BITS] = mask_q[WORD_BITS*word +: WORD_BITS] & ~wdata;
        default:  mask_d = mask_q;
      endcase
    end
  end

  // Output is computed from the next mask so that it moves one clock after a write.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '1;
      irq_q  <= 1'b0;
    end else begin
      mask_q <= mask_d;
      irq_q  <= |(src & ~mask_d);
    end
  end

  assign mask = mask_q;
  assign irq  = irq_q;
endmodule

// File: rtl/lia_read_mux.sv
module lia_read_mux #(
  parameter int N_WORDS = 2,
  parameter int N_CPUS  = 2,
  localparam int N_SRC  = N_WORDS * lia_pkg::WORD_BITS,
  localparam int WIDX_W = (N_WORDS > 1) ? $clog2(N_WORDS) : 1,
  localparam int CPU_W  = (N_CPUS > 1) ? $clog2(N_CPUS) : 1
) (
  input  lia_pkg::grp_e            grp,
  input  logic [WIDX_W-1:0]        word,
  input  logic                     hit,
  input  logic                     cpu_ok,
  input  logic [CPU_W-1:0]         cpu_sel,
  input  logic [N_SRC-1:0]         src,
  input  logic [N_CPUS*N_SRC-1:0]  masks,
  output logic [31:0]              rd_word
);
  import lia_pkg::*;

  always_comb begin
    if (!hit || !cpu_ok) begin
      rd_word = '0;
    end else if (grp == GRP_RAW) begin
      rd_word = src[WORD_BITS*word +: WORD_BITS];
    end else begin
      rd_word = masks[32'(cpu_sel)*N_SRC + WORD_BITS*word +: WORD_BITS];
    end
  end
endmodule

// File: rtl/lvl_irq_agg.sv
module lvl_irq_agg #(
  parameter int N_WORDS = 2,
  parameter int N_CPUS  = 2,
  parameter int ADDR_W  = 8,
  localparam int N_SRC  = N_WORDS * lia_pkg::WORD_BITS,
  localparam int CPU_W  = (N_CPUS > 1) ? $clog2(N_CPUS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_SRC-1:0]  src,
  input  logic              req,
  input  logic              we,
  input  logic [CPU_W-1:0]  cpu_sel,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       wdata,
  output logic [31:0]       rdata,
  output logic [N_CPUS-1:0] irq_out
);
  import lia_pkg::*;

  localparam int WIDX_W = (N_WORDS > 1) ? $clog2(N_WORDS) : 1;

  grp_e                    grp;
  logic [WIDX_W-1:0]       word;
  logic                    hit;
  logic                    cpu_ok;
  logic [N_CPUS*N_SRC-1:0] masks_flat;
  logic [31:0]             rd_word;
  logic [31:0]             rdata_q;

  assign cpu_ok = (32'(cpu_sel) < N_CPUS);

  lia_decode #(.N_WORDS(N_WORDS), .ADDR_W(ADDR_W)) u_dec (
    .addr(addr), .grp(grp), .word(word), .hit(hit)
  );

  for (genvar c = 0; c < N_CPUS; c++) begin : g_bank
    logic wr_c;
    assign wr_c = req && we && hit && cpu_ok && (32'(cpu_sel) == c);

    lia_mask_bank #(.N_WORDS(N_WORDS)) u_bank (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_c), .grp(grp), .word(word),
      .wdata(wdata), .src(src), .mask(masks_flat[c*N_SRC +: N_SRC]),
      .irq(irq_out[c])
    );
  end

  lia_read_mux #(.N_WORDS(N_WORDS), .N_CPUS(N_CPUS)) u_rmux (
    .grp(grp), .word(word), .hit(hit), .cpu_ok(cpu_ok), .cpu_sel(cpu_sel),
    .src(src), .masks(masks_flat), .rd_word(rd_word)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          rdata_q <= '0;
    else if (req && !we) rdata_q <= rd_word;
  end

  assign rdata = rdata_q;
endmodule

// File: rtl/lia_checker.sv
module lia_checker #(
  parameter int N_WORDS = 2,
  parameter int N_CPUS  = 2,
  parameter int ADDR_W  = 8,
  localparam int N_SRC  = N_WORDS * 32,
  localparam int CPU_W  = (N_CPUS > 1) ? $clog2(N_CPUS) : 1
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic [N_SRC-1:0]        src,
  input logic                    req,
  input logic                    we,
  input logic [CPU_W-1:0]        cpu_sel,
  input logic [ADDR_W-1:0]       addr,
  input logic [31:0]             wdata,
  input logic [31:0]             rdata,
  input logic [N_CPUS-1:0]       irq_out,
  input logic [N_CPUS*N_SRC-1:0] masks
);
  int unsigned slot, gi, wi, wi_q;
  logic        mapped;
  logic [31:0] src_word, wdata_q;
  logic [1:0]  unused_lo;

  assign unused_lo = addr[1:0];

  always_comb begin
    slot     = 32'(addr[ADDR_W-1:2]);
    mapped   = slot < 4 * N_WORDS;
    gi       = slot / N_WORDS;
    wi       = slot % N_WORDS;
    src_word = src[32*wi +: 32];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wi_q    <= 0;
      wdata_q <= '0;
    end else begin
      wi_q    <= wi;
      wdata_q <= wdata;
    end
  end

  // R7 and R10: writes to read-only or unmapped words leave every mask alone
  p_ro_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (req && we && (!mapped || gi < 2)) |=> $stable(masks));

  // R10: unmapped reads return zero
  p_oob_read_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (req && !we && !mapped) |=> (rdata == '0));

  // R3: raw-status reads return sampled source levels
  p_raw_read_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (req && !we && mapped && gi == 0 && 32'(cpu_sel) < N_CPUS) |=> (rdata == $past(src_word)));

  for (genvar c = 0; c < N_CPUS; c++) begin : g_cpu
    logic set_q, clr_q;
    logic [31:0] mw;

    assign mw = masks[c*N_SRC + 32*wi_q +: 32];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        set_q <= 1'b0;
        clr_q <= 1'b0;
      end else begin
        set_q <= req && we && mapped && gi == 2 && 32'(cpu_sel) == c;
        clr_q <= req && we && mapped && gi == 3 && 32'(cpu_sel) == c;
      end
    end

    // R4: ones written to a set word end up masked
    p_set_lands_r4: assert property (@(posedge clk) disable iff (!rst_n)
      set_q |-> ((mw & wdata_q) == wdata_q));

    // R5: ones written to a clear word end up unmasked
    p_clr_lands_r5: assert property (@(posedge clk) disable iff (!rst_n)
      clr_q |-> ((mw & wdata_q) == '0));

    // R9: an asserted output needs a source that was high one cycle earlier
    p_irq_backed_r9: assert property (@(posedge clk) disable iff (!rst_n)
      irq_out[c] |-> $past(|src));
  end
endmodule

bind lvl_irq_agg lia_checker #(.N_WORDS(N_WORDS), .N_CPUS(N_CPUS), .ADDR_W(ADDR_W)) u_lia_chk (
  .clk(clk), .rst_n(rst_n), .src(src), .req(req), .we(we), .cpu_sel(cpu_sel),
  .addr(addr), .wdata(wdata), .rdata(rdata), .irq_out(irq_out), .masks(masks_flat)
);

// File: tb/lvl_irq_agg_bench.sv
`timescale 1ns/1ps
module lvl_irq_agg_bench;
  localparam int NW = 2;
  localparam int NC = 2;
  localparam int AW = 8;
  localparam int NS = NW * 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NS-1:0] src = '0;
  logic          req = 1'b0, we = 1'b0;
  logic [0:0]    cpu_sel = '0;
  logic [AW-1:0] addr = '0;
  logic [31:0]   wdata = '0;
  logic [31:0]   rdata;
  logic [NC-1:0] irq_out;

  always #2 clk = ~clk;

  lvl_irq_agg #(.N_WORDS(NW), .N_CPUS(NC), .ADDR_W(AW)) u_lvl_irq_agg (
    .clk(clk), .rst_n(rst_n), .src(src), .req(req), .we(we), .cpu_sel(cpu_sel),
    .addr(addr), .wdata(wdata), .rdata(rdata), .irq_out(irq_out)
  );

  int n_chk = 0, n_bad = 0;
  logic [NS-1:0] mdl [NC];

  typedef struct { logic [31:0] exp; string tag; } item_t;
  item_t sbq[$];
  logic rd_seen = 1'b0;

  task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [AW-1:0] a_of(int g, int w);
    return AW'((g * NW + w) * 4);
  endfunction

  // Monitor: one read result per read request, compared against the scoreboard
  always @(posedge clk) rd_seen <= req && !we;
  always @(negedge clk) begin
    if (rd_seen) begin
      if (sbq.size() == 0) check(rdata, 32'hDEAD_BEEF, "R11 unexpected read data");
      else begin
        item_t it;
        it = sbq.pop_front();
        check(rdata, it.exp, it.tag);
      end
    end
  end

  task automatic do_wr(int c, int g, int w, logic [31:0] d);
    @(negedge clk);
    req = 1; we = 1; cpu_sel = c[0]; addr = a_of(g, w); wdata = d;
    if (g == 2) mdl[c][w*32 +: 32] = mdl[c][w*32 +: 32] | d;
    if (g == 3) mdl[c][w*32 +: 32] = mdl[c][w*32 +: 32] & ~d;
    @(negedge clk);
    req = 0; we = 0;
  endtask

  task automatic do_rd(int c, int g, int w, string tag);
    item_t it;
    it.tag = tag;
    if (g == 0)      it.exp = src[w*32 +: 32];
    else if (g <= 3) it.exp = mdl[c][w*32 +: 32];
    else             it.exp = '0;
    @(negedge clk);
    sbq.push_back(it);
    req = 1; we = 0; cpu_sel = c[0]; addr = a_of(g, w);
    @(negedge clk);
    req = 0;
  endtask

  task automatic chk_irq(string tag);
    logic [NC-1:0] e;
    for (int c = 0; c < NC; c++) e[c] = |(src & ~mdl[c]);
    check(32'(irq_out), 32'(e), tag);
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    for (int c = 0; c < NC; c++) mdl[c] = '1;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check(32'(irq_out), 0, "R1 outputs low after reset");
    check(rdata, 0, "R1 rdata zero after reset");
    do_rd(0, 1, 0, "R1 bank0 word0 masked");
    do_rd(1, 1, 1, "R1 bank1 word1 masked");

    @(negedge clk); src = {32'h8000_0001, 32'h0000_0030};
    @(negedge clk); chk_irq("R9 all masked keeps outputs low");
    do_rd(1, 0, 0, "R3 raw word0 while masked");
    do_rd(0, 0, 1, "R3 raw word1 while masked");

    do_wr(0, 3, 0, 32'h0000_0011);
    chk_irq("R5 clear unmasks source 4 for cpu0 only (R8)");
    do_rd(0, 1, 0, "R5 mask word after clear");
    do_rd(0, 2, 0, "R6 mask via set register");
    do_rd(0, 3, 0, "R6 mask via clear register");
    do_rd(1, 1, 0, "R8 other bank untouched");

    do_wr(0, 2, 0, 32'h0);
    do_rd(0, 1, 0, "R4 zero set bits no change");
    do_wr(0, 3, 0, 32'h0);
    do_rd(0, 1, 0, "R5 zero clear bits no change");

    do_wr(0, 0, 0, 32'hFFFF_FFFF);
    do_wr(0, 1, 0, 32'hFFFF_FFFF);
    do_rd(0, 1, 0, "R7 read-only writes ignored");
    chk_irq("R7 output unchanged after read-only writes");

    @(negedge clk); src[4] = 1'b0;
    @(negedge clk); chk_irq("R9 output drops with source");
    src[4] = 1'b1;
    @(negedge clk); chk_irq("R9 output rises with source");

    do_wr(1, 3, 1, 32'h8000_0000);
    chk_irq("R2 source 63 is word1 bit31 for cpu1");
    do_wr(0, 2, 0, 32'h0000_0010);
    chk_irq("R4 set masks source 4");

    do_rd(0, 4, 0, "R10 unmapped read is zero");
    do_wr(0, 4, 0, 32'hFFFF_FFFF);
    do_wr(1, 5, 1, 32'hFFFF_FFFF);
    do_rd(0, 1, 0, "R10 unmapped write ignored bank0");
    do_rd(1, 1, 1, "R10 unmapped write ignored bank1");
    chk_irq("R10 outputs unchanged");

    @(negedge clk);
    check(rdata, mdl[1][63:32], "R11 rdata holds without read");

    repeat (2) @(negedge clk);
    finish_run();
  end
endmodule